// File: doc/BRIEF.md
# Fair-Share Wired Interrupt Requester

This block produces the interrupt requests of one device that sits in a group of peer devices. The peers share active-low open-drain request lines, one line for each interrupt type. Three types are handled: receive, transmit and modem/other. For each type the block raises an open-drain enable that pulls the shared line low. It keeps that enable asserted until the host signals that the request has been serviced.

For each type the block keeps a fairness flag. Starting a request clears the flag. The flag is set again only after the shared line has been seen low and then back at its idle high level, which means every peer that was asserting alongside has also been serviced. While the flag is clear, a pending request waits. It is kept, not discarded, and it is issued once the flag sets. This gives round-robin service among peers without a central arbiter.

The types can each have their own line, or all three can be tied to one common line. The sensed line levels pass through a synchronizer before the flag logic uses them.

Top module: `fsirq_requester`

## Requirements
- R1: While rst_ni is low, every bit of drive_o is 0. Every fairness flag resets to set, so a request pending at the first clock edge after reset release asserts drive_o at that edge.
- R2: Bit k of each vector maps to one type: 0 receive, 1 transmit, 2 modem/other. When pend_i[k] is 1, the flag of type k is set and drive_o[k] is 0, drive_o[k] becomes 1 at the next clock edge and the flag of type k clears at that same edge. drive_o[k]=1 means the shared line is pulled low.
- R3: Once asserted, drive_o[k] stays 1 until an edge at which done_i[k] is 1. It is 0 after that edge.
- R4: While the sensed line_i[k] stays low, whether the device or a peer holds it there, the flag of type k stays clear and drive_o[k] is not asserted again.
- R5: line_i[k] passes through two synchronizer stages. After drive_o[k] falls on a line that then reads high, a still-pending request reasserts drive_o[k] at the 4th clock edge after the release edge and not earlier.
- R6: A request that is blocked by a clear flag is held. If pend_i[k] stays 1, drive_o[k] asserts without any new stimulus 4 edges after the line is sensed idle.
- R7: done_i[k] has no effect while drive_o[k] is 0.
- R8: The types are independent. done_i, pend_i and line_i of one type never change drive_o of another type on separate lines.
- R9: When all three lines are tied to one common line, a released type stays blocked until every type driving the common line has released. All blocked types then re-request together at the 4th edge after the last release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_TYPES | Internal pending request, one bit per type |
| line_i | input | N_TYPES | Sensed level of each shared request line (1 = idle high) |
| done_i | input | N_TYPES | Service-done pulse from the host, one bit per type |
| drive_o | output | N_TYPES | Open-drain enable; 1 pulls the shared line low |

## Verification
Two events can land on the same clock edge: the service-done release of one type, and the common-line return to idle that re-arms another type's flag. In common-line mode the bench releases two types with done pulses on separate edges, and then again on one shared edge. In both cases it expects each still-pending type to stay silent until the last release. Each type must then reassert exactly on the 4th edge after that release. The bench models the wired line itself, as the AND of every peer's and the device's open-drain pulls.

// File: rtl/fsirq_pkg.sv
package fsirq_pkg;
  localparam int unsigned NUM_TYPES_DEF = 3;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    IRQ_RX   = 2'd0,
    IRQ_TX   = 2'd1,
    IRQ_MISC = 2'd2
  } irq_type_e;

  typedef struct packed {
    logic fair;      // may start a new request
    logic seen_low;  // line sensed low since flag cleared
    logic drv;       // pulling the shared line low
  } lane_state_t;

  localparam lane_state_t LANE_RESET = '{fair: 1'b1, seen_low: 1'b0, drv: 1'b0};
endpackage

// File: rtl/fsirq_sync.sv
module fsirq_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;  // idle level of the lines
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fsirq_lane.sv
module fsirq_lane
  import fsirq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic line_hi_i,
  input  logic done_i,
  output logic drive_o,
  output logic fair_o
);
  lane_state_t q, d;

  always_comb begin
    d = q;
    if (q.drv) begin
      if (done_i) d.drv = 1'b0;
    end else if (pend_i && q.fair) begin
      d.drv      = 1'b1;
      d.fair     = 1'b0;
      d.seen_low = 1'b0;
    end
    // arm only after the line was seen low, so stale synced highs are ignored
    if (!q.fair && !line_hi_i) d.seen_low = 1'b1;
    if (!q.fair && !q.drv && q.seen_low && line_hi_i) begin
      d.fair     = 1'b1;
      d.seen_low = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= LANE_RESET;
    else q <= d;
  end

  assign drive_o = q.drv;
  assign fair_o  = q.fair;
endmodule

// File: rtl/fsirq_requester.sv
module fsirq_requester
  import fsirq_pkg::*;
#(
  parameter int unsigned N_TYPES     = NUM_TYPES_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_TYPES-1:0] pend_i,
  input  logic [N_TYPES-1:0] line_i,
  input  logic [N_TYPES-1:0] done_i,
  output logic [N_TYPES-1:0] drive_o
);
  logic [N_TYPES-1:0] line_hi;
  logic [N_TYPES-1:0] fair_w;

  fsirq_sync #(
    .WIDTH (N_TYPES),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_hi)
  );

  for (genvar k = 0; k < N_TYPES; k++) begin : g_lane
    fsirq_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pend_i   (pend_i[k]),
      .line_hi_i(line_hi[k]),
      .done_i   (done_i[k]),
      .drive_o  (drive_o[k]),
      .fair_o   (fair_w[k])
    );
  end
endmodule

// File: rtl/fsirq_requester_chk.sv
module fsirq_requester_chk #(
  parameter int unsigned N_TYPES = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_TYPES-1:0] pend_i,
  input logic [N_TYPES-1:0] done_i,
  input logic [N_TYPES-1:0] drive_i,
  input logic [N_TYPES-1:0] fair_i
);
  for (genvar k = 0; k < N_TYPES; k++) begin : g_chk
    AST_START_NEEDS_FAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(drive_i[k]) |-> $past(fair_i[k]) && $past(pend_i[k])); // R2
    AST_START_CLEARS_FAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(drive_i[k]) |-> !fair_i[k]); // R2
    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drive_i[k] && !done_i[k] |=> drive_i[k]); // R3
    AST_RELEASE_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drive_i[k] && done_i[k] |=> !drive_i[k]); // R3
    AST_BLOCKED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fair_i[k] && !drive_i[k] |=> !drive_i[k]); // R4
    AST_FAIR_CLEAR_WHILE_DRIVING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drive_i[k] |-> !fair_i[k]); // R4
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drive_i[k] && done_i[k] && !(pend_i[k] && fair_i[k]) |=> !drive_i[k]); // R7
  end
endmodule

bind fsirq_requester fsirq_requester_chk #(.N_TYPES(N_TYPES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pend_i (pend_i),
  .done_i (done_i),
  .drive_i(drive_o),
  .fair_i (fair_w)
);

// File: tb/tb_fsirq_requester.sv
module tb_fsirq_requester;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pend = '0, done = '0, peer = '0;
  logic         common = 1'b0;
  logic [N-1:0] line_w, drive;
  int           n_tests = 0, n_fail = 0;
  bit           finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired open-drain lines, pulled up
  always_comb begin
    if (common) line_w = {N{~|(drive | peer)}};
    else        line_w = ~(drive | peer);
  end

  fsirq_requester dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pend_i (pend),
    .line_i (line_w),
    .done_i (done),
    .drive_o(drive)
  );

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pend = '0; done = '0; peer = '0; common = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse_done(input logic [N-1:0] m);
    done = m;
    tick();
    done = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; pend = 3'b111;
    tick(2);
    chk("R1 drive low in reset", drive, 3'b000);
    pend = '0;
    rst_n = 1'b1;
    pend = 3'b001;
    tick();
    chk("R1 request right after reset", drive, 3'b001);
  endtask

  task automatic t_start_hold();
    do_reset();
    pend = 3'b100;
    tick();
    chk("R2 misc type starts", drive, 3'b100);
    pend = '0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R3 held until done", drive, 3'b100);
    end
    pulse_done(3'b100);
    chk("R3 released on done", drive, 3'b000);
  endtask

  task automatic t_rearm();
    do_reset();
    pend = 3'b001;
    tick();
    chk("R2 rx starts", drive, 3'b001);
    tick(4);
    pulse_done(3'b001);
    chk("R3 rx released", drive, 3'b000);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 no early re-request", drive, 3'b000);
    end
    tick();
    chk("R5 re-request on 4th edge", drive, 3'b001);
  endtask

  task automatic t_peer();
    do_reset();
    peer = 3'b010;
    pend = 3'b010;
    tick();
    chk("R2 joins line held by peer", drive, 3'b010);
    tick(3);
    pulse_done(3'b010);
    chk("R3 tx released", drive, 3'b000);
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R4 blocked while peer holds line", drive, 3'b000);
    end
    peer = '0;
    tick(3);
    chk("R6 still waiting for sync", drive, 3'b000);
    tick();
    chk("R6 held request issued", drive, 3'b010);
  endtask

  task automatic t_done_idle();
    do_reset();
    done = 3'b111;
    tick(3);
    done = '0;
    chk("R7 done ignored when idle", drive, 3'b000);
    pend = 3'b001;
    tick();
    chk("R7 flag intact after idle done", drive, 3'b001);
  endtask

  task automatic t_indep();
    do_reset();
    pend = 3'b011;
    tick();
    chk("R8 rx and tx start", drive, 3'b011);
    pulse_done(3'b010);
    chk("R8 tx done leaves rx", drive, 3'b001);
    peer = 3'b100;
    tick(3);
    chk("R8 misc line activity no effect", drive, 3'b001);
    tick();
    chk("R8 tx re-requests, rx held", drive, 3'b011);
  endtask

  task automatic t_common();
    do_reset();
    common = 1'b1;
    pend = 3'b011;
    tick();
    chk("R9 both start on common line", drive, 3'b011);
    pulse_done(3'b001);
    chk("R9 rx released", drive, 3'b010);
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R9 rx blocked by tx on common line", drive, 3'b010);
    end
    pulse_done(3'b010);
    chk("R9 tx released", drive, 3'b000);
    tick(3);
    chk("R9 no early re-request", drive, 3'b000);
    tick();
    chk("R9 both re-request together", drive, 3'b011);
    // simultaneous release of both types
    pulse_done(3'b011);
    chk("R9 same-edge release", drive, 3'b000);
    tick(3);
    chk("R9 wait after same-edge release", drive, 3'b000);
    tick();
    chk("R9 re-request after same-edge release", drive, 3'b011);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_start_hold();
    t_rearm();
    t_peer();
    t_done_idle();
    t_indep();
    t_common();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule